// File: doc/BRIEF.md
# Tagged Bidirectional Parallel-Port FIFO

This block is the byte queue between the host bus and the handshake engine of an extended-capabilities parallel port. Each entry holds a data byte and a one-bit tag that marks the byte as a command or as plain data. A single storage array serves both transfer directions. In the forward direction the host fills the queue by programmed I/O or DMA and the port engine drains it. In the backward direction the port engine fills it and the host drains it.

The mode controller holds `mode_fifo_en` high while the port is in one of its FIFO modes. When that input drops, the queue empties itself and emits a one-cycle terminate pulse to the run-length expander, even while the block clock is frozen. A power-down freeze input stops all transfers without losing the contents, and it silences the interrupt and the DMA request. Each direction has its own threshold interrupt, compared against a programmable level.

Top module: `ecp_tag_fifo`

## Requirements
- R1: After reset, with `mode_fifo_en` low, `sts_empty`=1, `sts_full`=0, and `thr_irq`, `dma_req`, `port_go` and `rle_abort` are all 0.
- R2: Forward (`dir_rev`=0): `sys_wr` pushes {`sys_wtag`,`sys_wdata`} and `port_rd` pops. `head_tag`/`head_data` show the oldest entry, and entries leave in write order (tag 1 = command, 0 = data).
- R3: The queue holds 16 entries. After 16 pushes `sts_full`=1, a further push is dropped and stored entries are unchanged. `sts_empty` and `sts_full` are never both 1.
- R4: A pop of an empty queue is dropped. The queue stays empty and the next pushed entry is read back correctly.
- R5: Backward (`dir_rev`=1): `port_wr` pushes {`port_wtag`,`port_wdata`} and `sys_rd` pops, in write order.
- R6: Requests from the wrong side are ignored. In forward mode `sys_rd` and `port_wr` have no effect; in backward mode `sys_wr` and `port_rd` have no effect.
- R7: `thr_irq` is 1 when the queue is enabled and not frozen, and the free entries (forward) or filled entries (backward) are at least `thresh`.
- R8: `dma_req` is 1 when the queue is enabled, not frozen and `dma_en`=1, and either the direction is forward with the queue not full, or backward with the queue not empty. It is always 0 while frozen.
- R9: `port_go` allows a new port-side transfer when the queue is enabled and not frozen, and either the direction is forward with the queue not empty, or backward with the queue not full.
- R10: While `clk_frozen`=1, all pushes and pops are ignored and the contents and flags are held. After the freeze ends they read back unchanged.
- R11: One cycle after `mode_fifo_en` is low, the queue is empty, whether or not it is frozen.
- R12: `rle_abort` is a single-cycle pulse in the cycle after `mode_fifo_en` falls, and it coincides with an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_fifo_en | input | 1 | High while the port is in a FIFO mode; low clears the queue |
| clk_frozen | input | 1 | Power-down freeze |
| dir_rev | input | 1 | 0 forward (host to peripheral), 1 backward |
| dma_en | input | 1 | Allows DMA requests |
| thresh | input | 5 | Threshold level for the interrupt |
| sys_wr | input | 1 | Host push request |
| sys_wtag | input | 1 | Host tag to push |
| sys_wdata | input | 8 | Host byte to push |
| sys_rd | input | 1 | Host pop request |
| port_wr | input | 1 | Port-engine push request |
| port_wtag | input | 1 | Port-engine tag to push |
| port_wdata | input | 8 | Port-engine byte to push |
| port_rd | input | 1 | Port-engine pop request |
| head_tag | output | 1 | Tag of the oldest entry |
| head_data | output | 8 | Byte of the oldest entry |
| sts_empty | output | 1 | Queue empty |
| sts_full | output | 1 | Queue full |
| thr_irq | output | 1 | Threshold interrupt |
| dma_req | output | 1 | DMA service request |
| port_go | output | 1 | Port engine may start a transfer |
| rle_abort | output | 1 | Terminate pulse to the run-length expander |

## Verification
The hold property for the freeze assumes that `mode_fifo_en` stays high in the same cycle, because a mode exit is allowed to clear a frozen queue. The stimulus therefore changes the mode only in a separate step, and drops it during a freeze only in the test that targets clearing. The properties also assume that `mode_fifo_en` is low during reset. The bench keeps it low there and raises it only after `rst_n` is released. All requests are driven as single-cycle pulses from one side at a time, which keeps each push or pop count known at every sample.

// File: rtl/ecp_fifo_pkg.sv
package ecp_fifo_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              tag;
        logic [BYTE_W-1:0] data;
    } fifo_entry_t;
endpackage

// File: rtl/ecp_fifo_mem.sv
module ecp_fifo_mem
    import ecp_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        we,
    input  logic [PTR_W-1:0] waddr,
    input  fifo_entry_t wentry,
    input  logic [PTR_W-1:0] raddr,
    output fifo_entry_t rentry
);
    fifo_entry_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == PTR_W'(g))) begin
                slot_q[g] <= wentry;
            end
        end
    end

    assign rentry = slot_q[raddr];
endmodule

// File: rtl/ecp_fifo_ptr.sv
module ecp_fifo_ptr #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    output logic             do_push,
    output logic             do_pop,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        empty   = (st_q.cnt == '0);
        full    = (st_q.cnt == CNT_W'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (clear) begin
            st_d = '0;
        end else begin
            if (do_push) begin
                st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
            end
            if (do_pop) begin
                st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;
    assign count  = st_q.cnt;
endmodule

// File: rtl/ecp_fifo_flags.sv
module ecp_fifo_flags #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             frozen,
    input  logic             dir_rev,
    input  logic             dma_en,
    input  logic [CNT_W-1:0] thresh,
    input  logic [CNT_W-1:0] count,
    input  logic             empty,
    input  logic             full,
    output logic             thr_irq,
    output logic             dma_req,
    output logic             port_go,
    output logic             rle_abort
);
    typedef struct packed {
        logic active;
        logic abort;
    } flag_state_t;

    flag_state_t st_d, st_q;
    logic [CNT_W-1:0] free_cnt;
    logic [CNT_W-1:0] level;
    logic             live;

    always_comb begin
        st_d.active = active;
        st_d.abort  = st_q.active && !active;

        live     = active && !frozen;
        free_cnt = CNT_W'(DEPTH) - count;
        level    = dir_rev ? count : free_cnt;
        thr_irq  = live && (level >= thresh);
        dma_req  = live && dma_en && (dir_rev ? !empty : !full);
        port_go  = live && (dir_rev ? !full : !empty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rle_abort = st_q.abort;
endmodule

// File: rtl/ecp_tag_fifo.sv
module ecp_tag_fifo
    import ecp_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_fifo_en,
    input  logic              clk_frozen,
    input  logic              dir_rev,
    input  logic              dma_en,
    input  logic [CNT_W-1:0]  thresh,
    input  logic              sys_wr,
    input  logic              sys_wtag,
    input  logic [BYTE_W-1:0] sys_wdata,
    input  logic              sys_rd,
    input  logic              port_wr,
    input  logic              port_wtag,
    input  logic [BYTE_W-1:0] port_wdata,
    input  logic              port_rd,
    output logic              head_tag,
    output logic [BYTE_W-1:0] head_data,
    output logic              sts_empty,
    output logic              sts_full,
    output logic              thr_irq,
    output logic              dma_req,
    output logic              port_go,
    output logic              rle_abort
);
    logic             gate;
    logic             push_req, pop_req;
    logic             do_push, do_pop;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    fifo_entry_t      wentry, rentry;

    always_comb begin
        gate     = mode_fifo_en && !clk_frozen;
        push_req = gate && (dir_rev ? port_wr : sys_wr);
        pop_req  = gate && (dir_rev ? sys_rd : port_rd);
        wentry   = dir_rev ? fifo_entry_t'{tag: port_wtag, data: port_wdata}
                           : fifo_entry_t'{tag: sys_wtag,  data: sys_wdata};
    end

    ecp_fifo_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!mode_fifo_en),
        .push    (push_req),
        .pop     (pop_req),
        .do_push (do_push),
        .do_pop  (do_pop),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .count   (count),
        .empty   (sts_empty),
        .full    (sts_full)
    );

    ecp_fifo_mem #(.DEPTH(DEPTH)) u_mem (
        .clk    (clk),
        .we     (do_push),
        .waddr  (wr_ptr),
        .wentry (wentry),
        .raddr  (rd_ptr),
        .rentry (rentry)
    );

    ecp_fifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (mode_fifo_en),
        .frozen    (clk_frozen),
        .dir_rev   (dir_rev),
        .dma_en    (dma_en),
        .thresh    (thresh),
        .count     (count),
        .empty     (sts_empty),
        .full      (sts_full),
        .thr_irq   (thr_irq),
        .dma_req   (dma_req),
        .port_go   (port_go),
        .rle_abort (rle_abort)
    );

    assign head_tag  = rentry.tag;
    assign head_data = rentry.data;
endmodule

// File: rtl/ecp_tag_fifo_chk.sv
module ecp_tag_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_fifo_en,
    input logic       clk_frozen,
    input logic       head_tag,
    input logic [7:0] head_data,
    input logic       sts_empty,
    input logic       sts_full,
    input logic       dma_req,
    input logic       port_go,
    input logic       rle_abort
);
    assert_flags_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sts_empty && sts_full));

    assert_clear_on_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_fifo_en |=> sts_empty);

    assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_frozen && mode_fifo_en) |=> ($stable(sts_empty) && $stable(sts_full)
                                          && $stable(head_data) && $stable(head_tag)));

    assert_dma_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_frozen |-> !dma_req);

    assert_no_start_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_frozen |-> !port_go);

    assert_abort_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rle_abort |=> !rle_abort);

    assert_abort_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rle_abort |-> sts_empty);
endmodule

bind ecp_tag_fifo ecp_tag_fifo_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_fifo_en (mode_fifo_en),
    .clk_frozen   (clk_frozen),
    .head_tag     (head_tag),
    .head_data    (head_data),
    .sts_empty    (sts_empty),
    .sts_full     (sts_full),
    .dma_req      (dma_req),
    .port_go      (port_go),
    .rle_abort    (rle_abort)
);

// File: tb/ecp_tag_fifo_bench.sv
`timescale 1ns/1ps
module ecp_tag_fifo_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_fifo_en = 1'b0, clk_frozen = 1'b0, dir_rev = 1'b0, dma_en = 1'b0;
    logic [4:0] thresh = 5'd8;
    logic       sys_wr = 1'b0, sys_wtag = 1'b0, sys_rd = 1'b0;
    logic [7:0] sys_wdata = 8'h00;
    logic       port_wr = 1'b0, port_wtag = 1'b0, port_rd = 1'b0;
    logic [7:0] port_wdata = 8'h00;
    logic       head_tag, sts_empty, sts_full, thr_irq, dma_req, port_go, rle_abort;
    logic [7:0] head_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ecp_tag_fifo u_ecp_tag_fifo (
        .clk(clk), .rst_n(rst_n), .mode_fifo_en(mode_fifo_en), .clk_frozen(clk_frozen),
        .dir_rev(dir_rev), .dma_en(dma_en), .thresh(thresh),
        .sys_wr(sys_wr), .sys_wtag(sys_wtag), .sys_wdata(sys_wdata), .sys_rd(sys_rd),
        .port_wr(port_wr), .port_wtag(port_wtag), .port_wdata(port_wdata), .port_rd(port_rd),
        .head_tag(head_tag), .head_data(head_data), .sts_empty(sts_empty), .sts_full(sts_full),
        .thr_irq(thr_irq), .dma_req(dma_req), .port_go(port_go), .rle_abort(rle_abort)
    );

    task automatic cyc();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic host_write(input bit t, input logic [7:0] d);
        sys_wr = 1'b1; sys_wtag = t; sys_wdata = d;
        cyc();
        sys_wr = 1'b0;
    endtask

    task automatic port_write(input bit t, input logic [7:0] d);
        port_wr = 1'b1; port_wtag = t; port_wdata = d;
        cyc();
        port_wr = 1'b0;
    endtask

    task automatic port_read();
        port_rd = 1'b1;
        cyc();
        port_rd = 1'b0;
    endtask

    task automatic host_read();
        sys_rd = 1'b1;
        cyc();
        sys_rd = 1'b0;
    endtask

    task automatic expect_head(input string req, input bit t, input logic [7:0] d);
        chk_eq(req, {head_tag, head_data}, {t, d});
    endtask

    task automatic t_reset();
        chk_eq("R1 empty", sts_empty, 1);
        chk_eq("R1 full", sts_full, 0);
        chk_eq("R1 outputs", {thr_irq, dma_req, port_go, rle_abort}, 0);
        mode_fifo_en = 1'b1; dma_en = 1'b1; thresh = 5'd8;
        cyc();
        chk_eq("R7 fwd irq on empty", thr_irq, 1);
        chk_eq("R8 fwd dma on empty", dma_req, 1);
        chk_eq("R9 no go when empty fwd", port_go, 0);
    endtask

    task automatic t_forward();
        host_write(1'b1, 8'hA1);
        host_write(1'b0, 8'hB2);
        host_write(1'b0, 8'hC3);
        chk_eq("R9 go fwd", port_go, 1);
        expect_head("R2 head0", 1'b1, 8'hA1);
        port_read();
        expect_head("R2 head1", 1'b0, 8'hB2);
        port_read();
        expect_head("R2 head2", 1'b0, 8'hC3);
        port_read();
        chk_eq("R2 drained", sts_empty, 1);
    endtask

    task automatic t_full();
        for (int i = 0; i < 16; i++) host_write(i[0], 8'h10 + 8'(i));
        chk_eq("R3 full", sts_full, 1);
        chk_eq("R7 irq off when full fwd", thr_irq, 0);
        chk_eq("R8 no dma when full fwd", dma_req, 0);
        host_write(1'b1, 8'hEE);
        chk_eq("R3 still full", sts_full, 1);
        for (int i = 0; i < 16; i++) begin
            expect_head("R3 order after drop", i[0], 8'h10 + 8'(i));
            port_read();
        end
        chk_eq("R3 drop left 16", sts_empty, 1);
    endtask

    task automatic t_empty_read();
        port_read();
        chk_eq("R4 still empty", sts_empty, 1);
        host_write(1'b0, 8'h5A);
        expect_head("R4 next entry", 1'b0, 8'h5A);
        port_read();
        chk_eq("R4 empty again", sts_empty, 1);
    endtask

    task automatic t_side_ignore_fwd();
        host_write(1'b1, 8'h33);
        host_read();
        expect_head("R6 sys_rd ignored fwd", 1'b1, 8'h33);
        port_write(1'b0, 8'h44);
        port_read();
        chk_eq("R6 port_wr ignored fwd", sts_empty, 1);
    endtask

    task automatic t_backward();
        dir_rev = 1'b1; thresh = 5'd4;
        cyc();
        chk_eq("R7 bwd irq off empty", thr_irq, 0);
        chk_eq("R9 go bwd", port_go, 1);
        chk_eq("R8 no dma bwd empty", dma_req, 0);
        for (int i = 0; i < 4; i++) port_write(~i[0], 8'hC0 + 8'(i));
        chk_eq("R7 bwd irq at level", thr_irq, 1);
        chk_eq("R8 dma bwd", dma_req, 1);
        host_write(1'b0, 8'hFF);
        port_read();
        for (int i = 0; i < 4; i++) begin
            expect_head("R5 bwd order / R6 ignored", ~i[0], 8'hC0 + 8'(i));
            host_read();
        end
        chk_eq("R6 bwd count exact", sts_empty, 1);
        dir_rev = 1'b0; thresh = 5'd8;
        cyc();
    endtask

    task automatic t_freeze();
        host_write(1'b0, 8'h77);
        host_write(1'b1, 8'h88);
        clk_frozen = 1'b1;
        cyc();
        chk_eq("R7/R8/R9 quiet frozen", {thr_irq, dma_req, port_go}, 0);
        host_write(1'b0, 8'h99);
        port_read();
        chk_eq("R10 flags held", {sts_empty, sts_full}, 0);
        clk_frozen = 1'b0;
        cyc();
        expect_head("R10 head kept", 1'b0, 8'h77);
        port_read();
        expect_head("R10 second kept", 1'b1, 8'h88);
        port_read();
        chk_eq("R10 no extra entry", sts_empty, 1);
    endtask

    task automatic t_clear();
        for (int i = 0; i < 3; i++) host_write(1'b0, 8'h60 + 8'(i));
        chk_eq("R12 no abort yet", rle_abort, 0);
        clk_frozen = 1'b1;
        mode_fifo_en = 1'b0;
        cyc();
        chk_eq("R11 cleared while frozen", sts_empty, 1);
        chk_eq("R12 abort pulse", rle_abort, 1);
        cyc();
        chk_eq("R12 abort one cycle", rle_abort, 0);
        clk_frozen = 1'b0;
        mode_fifo_en = 1'b1;
        cyc();
        chk_eq("R11 still empty after return", sts_empty, 1);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc();
        cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_forward();
        t_full();
        t_empty_read();
        t_side_ignore_fwd();
        t_backward();
        t_freeze();
        t_clear();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule